// File: doc/BRIEF.md
# Four-Channel Power-Good Qualifier

The block decides, for each of four supply channels, whether the channel is good, and drives one power-good output per channel. A channel is in window when its 10-bit digitized monitor voltage lies inside the channel's own undervoltage and overvoltage critical limits, with both limits counted as inside. A channel that stays in window is not reported as good at once. It must stay in window for a qualification delay, counted in millisecond timebase ticks. Each channel has its own 2-bit delay code. When the channel leaves the window, its good flag drops in the same cycle and the delay count starts again from zero.

A small register port gives access to two registers. The status register holds the four good flags, an alert bit that software can write, a read-only copy of the polarity pin and a read-only retry bit. The delay register holds the four delay codes. A status flag of 1 always means good. The external polarity pin can change at any time. It inverts only the power-good outputs, and the outputs follow it without waiting for a clock edge.

Top module: `pwr_good_qual`

## Requirements
- R1: Channel n (n = 0..3) uses `monVolt`, `uvLimit` and `ovLimit` bits [10n+9:10n], read as unsigned values. The channel is in window only when uvLimit <= monVolt <= ovLimit. If uvLimit > ovLimit, the channel is never in window.
- R2: Once a channel has entered the window, its good flag rises on the clock edge that samples the Nth `msTick` high after the entry edge. N is 50 for code 00, 100 for code 01, 200 for code 10 and 400 for code 11. A tick on the entry edge itself is not counted.
- R3: The delay register is at address 0x66 and reads back what was last written to it. Channel n's code is in bits [2n+1:2n].
- R4: The status register is at address 0x62. Bits [3:0] are the good flags of channels 0..3. Bit 4 is the alert bit, which can be read and written. Bit 5 reads `polHigh`. Bit 6 reads `retryMode`. Bit 7 reads 0. A write to 0x62 changes only bit 4. Reads of any other address return 0.
- R5: A status flag reads 1 for a good channel, whatever the level of `polHigh`.
- R6: `pgOut[n]` equals the good flag when `polHigh` is 1, and its inverse when `polHigh` is 0. It follows a change of `polHigh` combinationally, with no clock edge.
- R7: When a good channel's voltage leaves the window, its status flag and `pgOut` change combinationally in the same cycle.
- R8: If a channel leaves the window before its delay has expired, the tick count is discarded. The next entry starts a full new delay.
- R9: A write to the delay register while a channel is timing does not change that channel's delay in progress. The new code applies from the channel's next entry into the window.
- R10: After reset, all good flags are 0, the delay register reads 0x00 and the alert bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse per millisecond |
| monVolt | input | 40 | Four 10-bit monitor voltages, channel 0 in bits [9:0] |
| uvLimit | input | 40 | Four 10-bit undervoltage critical limits |
| ovLimit | input | 40 | Four 10-bit overvoltage critical limits |
| polHigh | input | 1 | 1: outputs active-high; 0: outputs active-low |
| retryMode | input | 1 | Level shown in status bit 6 |
| regAddr | input | 8 | Register address for read and write |
| regWrEn | input | 1 | Write strobe for regWrData at regAddr |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| pgOut | output | 4 | Per-channel power-good outputs |

## Verification
A channel sequencer in the wrong state shows up in one of two ways. The channel reports good too early, or it stays low past its delay. The bench catches both because it samples the flag one tick before and one tick after the expected edge. A counter that is not cleared when the window is lost makes a re-entered channel turn good early, within the shortened delay. A target latched at the wrong moment shifts the good edge by a whole delay step. Errors in polarity and deassertion are combinational, so the bench checks for them within a nanosecond of the input change and before the next clock edge.

// File: rtl/pgq_pkg.sv
package pgq_pkg;
  localparam int NUM_CH      = 4;
  localparam int CODE_W      = 2;
  localparam int REG_W       = 8;
  localparam logic [7:0] ADDR_STATUS = 8'h62;
  localparam logic [7:0] ADDR_DELAY  = 8'h66;

  typedef struct packed {
    logic load;
    logic inc;
    logic clr;
  } chStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TIMING,
    ST_GOOD
  } chState_e;
endpackage

// File: rtl/pgq_regs.sv
module pgq_regs
  import pgq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [NUM_CH-1:0] pgFlags,
  input  logic              polHigh,
  input  logic              retryMode,
  output logic [REG_W-1:0]  delayCodes,
  output logic [REG_W-1:0]  rdData
);
  logic alertQ;
  logic wrDelay;
  logic wrStatus;

  assign wrDelay  = regWrEn && (regAddr == ADDR_DELAY);
  assign wrStatus = regWrEn && (regAddr == ADDR_STATUS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCodes <= '0;
      alertQ     <= 1'b0;
    end else begin
      if (wrDelay)  delayCodes <= regWrData;
      if (wrStatus) alertQ     <= regWrData[4];
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_STATUS: rdData = {1'b0, retryMode, polHigh, alertQ, pgFlags};
      ADDR_DELAY:  rdData = delayCodes;
      default:     rdData = '0;
    endcase
  end

  AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_DELAY) |=> $stable(delayCodes)); // R3

  AST_ALERT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_STATUS) |=> $stable(alertQ)); // R4
endmodule

// File: rtl/pgq_datapath.sv
module pgq_datapath
  import pgq_pkg::*;
#(
  parameter int VoltW     = 10,
  parameter int BaseTicks = 50,
  localparam int CntW     = $clog2((BaseTicks << 3) + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH*VoltW-1:0]  monVolt,
  input  logic [NUM_CH*VoltW-1:0]  uvLimit,
  input  logic [NUM_CH*VoltW-1:0]  ovLimit,
  input  logic [REG_W-1:0]         delayCodes,
  input  chStrobe_t [NUM_CH-1:0]   stb,
  output logic [NUM_CH-1:0]        inWin,
  output logic [NUM_CH-1:0]        atLast
);
  localparam logic [CntW-1:0] BaseV = CntW'(BaseTicks);

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [VoltW-1:0] volt;
    logic [VoltW-1:0] lo;
    logic [VoltW-1:0] hi;
    logic [CntW-1:0]  cntQ;
    logic [CntW-1:0]  targetQ;
    logic [CODE_W-1:0] code;

    assign volt = monVolt[g*VoltW +: VoltW];
    assign lo   = uvLimit[g*VoltW +: VoltW];
    assign hi   = ovLimit[g*VoltW +: VoltW];
    assign code = delayCodes[g*CODE_W +: CODE_W];

    assign inWin[g]  = (volt >= lo) && (volt <= hi);
    assign atLast[g] = (cntQ == targetQ - 1'b1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ    <= '0;
        targetQ <= '0;
      end else if (stb[g].load) begin
        cntQ    <= '0;
        targetQ <= BaseV << code;
      end else if (stb[g].clr) begin
        cntQ    <= '0;
      end else if (stb[g].inc) begin
        cntQ    <= cntQ + 1'b1;
      end
    end

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      stb[g].load |=> (cntQ == '0)); // R8

    AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ < targetQ) || (cntQ == '0)); // R2
  end
endmodule

// File: rtl/pgq_control.sv
module pgq_control
  import pgq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   msTick,
  input  logic [NUM_CH-1:0]      inWin,
  input  logic [NUM_CH-1:0]      atLast,
  output chStrobe_t [NUM_CH-1:0] stb,
  output logic [NUM_CH-1:0]      goodState
);
  for (genvar g = 0; g < NUM_CH; g++) begin : gSeq
    chState_e  stQ;
    chState_e  stD;
    chStrobe_t s;

    always_comb begin
      stD = stQ;
      s   = '0;
      case (stQ)
        ST_IDLE: begin
          if (inWin[g]) begin
            s.load = 1'b1;
            stD    = ST_TIMING;
          end
        end
        ST_TIMING: begin
          if (!inWin[g]) begin
            s.clr = 1'b1;
            stD   = ST_IDLE;
          end else if (msTick) begin
            if (atLast[g]) stD   = ST_GOOD;
            else           s.inc = 1'b1;
          end
        end
        ST_GOOD: begin
          if (!inWin[g]) begin
            s.clr = 1'b1;
            stD   = ST_IDLE;
          end
        end
        default: stD = ST_IDLE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) stQ <= ST_IDLE;
      else       stQ <= stD;
    end

    assign stb[g]       = s;
    assign goodState[g] = (stQ == ST_GOOD);

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
      $rose(goodState[g]) |-> $past(msTick)); // R2

    AST_DROP_OUT: assert property (@(posedge clk) disable iff (!rstN)
      !inWin[g] |=> !goodState[g]); // R7
  end
endmodule

// File: rtl/pwr_good_qual.sv
module pwr_good_qual
  import pgq_pkg::*;
#(
  parameter int VoltW     = 10,
  parameter int BaseTicks = 50
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    msTick,
  input  logic [NUM_CH*VoltW-1:0] monVolt,
  input  logic [NUM_CH*VoltW-1:0] uvLimit,
  input  logic [NUM_CH*VoltW-1:0] ovLimit,
  input  logic                    polHigh,
  input  logic                    retryMode,
  input  logic [7:0]              regAddr,
  input  logic                    regWrEn,
  input  logic [REG_W-1:0]        regWrData,
  output logic [REG_W-1:0]        regRdData,
  output logic [NUM_CH-1:0]       pgOut
);
  chStrobe_t [NUM_CH-1:0] stb;
  logic [NUM_CH-1:0] inWin;
  logic [NUM_CH-1:0] atLast;
  logic [NUM_CH-1:0] goodState;
  logic [NUM_CH-1:0] pgFlags;
  logic [REG_W-1:0]  delayCodes;

  pgq_datapath #(.VoltW(VoltW), .BaseTicks(BaseTicks)) uDp (
    .clk(clk), .rstN(rstN), .monVolt(monVolt), .uvLimit(uvLimit),
    .ovLimit(ovLimit), .delayCodes(delayCodes), .stb(stb),
    .inWin(inWin), .atLast(atLast)
  );

  pgq_control uCtl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .inWin(inWin),
    .atLast(atLast), .stb(stb), .goodState(goodState)
  );

  pgq_regs uRegs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .pgFlags(pgFlags), .polHigh(polHigh),
    .retryMode(retryMode), .delayCodes(delayCodes), .rdData(regRdData)
  );

  assign pgFlags = goodState & inWin;
  assign pgOut   = polHigh ? pgFlags : ~pgFlags;

  AST_OUT_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STATUS) |->
      (regRdData[NUM_CH-1:0] == (polHigh ? pgOut : ~pgOut))); // R6
endmodule

// File: tb/sim_pwr_good_qual.sv
module sim_pwr_good_qual;
  logic        clk = 1'b0;
  logic        rstN;
  logic        msTick;
  logic [39:0] monVolt, uvLimit, ovLimit;
  logic        polHigh, retryMode;
  logic [7:0]  regAddr, regWrData, regRdData;
  logic        regWrEn;
  logic [3:0]  pgOut;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_good_qual u0 (
    .clk(clk), .rstN(rstN), .msTick(msTick), .monVolt(monVolt),
    .uvLimit(uvLimit), .ovLimit(ovLimit), .polHigh(polHigh),
    .retryMode(retryMode), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pgOut(pgOut)
  );

  // {volt, uv, ov, expected in-window}
  localparam logic [30:0] VEC [8] = '{
    {10'd500,  10'd100,  10'd900,  1'b1},
    {10'd100,  10'd100,  10'd900,  1'b1},
    {10'd900,  10'd100,  10'd900,  1'b1},
    {10'd99,   10'd100,  10'd900,  1'b0},
    {10'd901,  10'd100,  10'd900,  1'b0},
    {10'd0,    10'd0,    10'd0,    1'b1},
    {10'd1023, 10'd0,    10'd1023, 1'b1},
    {10'd1023, 10'd1023, 10'd1022, 1'b0}
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic setCh(int ch, int v, int lo, int hi);
    monVolt[ch*10 +: 10] = 10'(v);
    uvLimit[ch*10 +: 10] = 10'(lo);
    ovLimit[ch*10 +: 10] = 10'(hi);
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      msTick = 1'b1;
      repeat (n) @(negedge clk);
      msTick = 1'b0;
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  logic [7:0] rd;

  initial begin
    rstN = 1'b0; msTick = 1'b0; polHigh = 1'b1; retryMode = 1'b0;
    regAddr = 8'h00; regWrEn = 1'b0; regWrData = 8'h00;
    monVolt = '0; uvLimit = '0; ovLimit = '0;
    for (int c = 0; c < 4; c++) setCh(c, 0, 100, 900);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    check("R10 pgOut after reset", 32'(pgOut), 32'h0);
    regRead(8'h66, rd); check("R10 delay reg reset", 32'(rd), 32'h00);
    regRead(8'h62, rd); check("R10 status reset", 32'(rd), 32'h20);

    // Status register layout and write masking
    regWrite(8'h62, 8'hFF);
    regRead(8'h62, rd); check("R4 status after 0xFF write", 32'(rd), 32'h30);
    retryMode = 1'b1;
    regRead(8'h62, rd); check("R4 retry bit", 32'(rd), 32'h70);
    regWrite(8'h62, 8'h00);
    regRead(8'h62, rd); check("R4 alert cleared", 32'(rd), 32'h60);
    retryMode = 1'b0;
    regRead(8'h10, rd); check("R4 unmapped read", 32'(rd), 32'h00);

    // Delay register read-back
    regWrite(8'h66, 8'hE4);
    regRead(8'h66, rd); check("R3 delay read-back", 32'(rd), 32'hE4);
    regWrite(8'h66, 8'h00);
    regRead(8'h66, rd); check("R3 delay cleared", 32'(rd), 32'h00);

    // Window vectors on channel 0, code 00
    foreach (VEC[i]) begin
      setCh(0, 0, 1023, 0);
      @(negedge clk);
      setCh(0, int'(VEC[i][30:21]), int'(VEC[i][20:11]), int'(VEC[i][10:1]));
      @(negedge clk);
      ticks(50);
      regRead(8'h62, rd);
      check($sformatf("R1 vector %0d status", i), 32'(rd[0]), 32'(VEC[i][0]));
      check($sformatf("R5 vector %0d pgOut", i), 32'(pgOut[0]), 32'(VEC[i][0]));
    end
    setCh(0, 0, 100, 900);
    @(negedge clk);

    // Delay codes: channel c uses code c
    regWrite(8'h66, 8'hE4);
    for (int c = 0; c < 4; c++) begin
      setCh(c, 500, 100, 900);
      @(negedge clk);
      ticks((50 << c) - 1);
      check($sformatf("R2 ch%0d one tick early", c), 32'(pgOut[c]), 32'h0);
      ticks(1);
      check($sformatf("R2 ch%0d on time", c), 32'(pgOut[c]), 32'h1);
    end

    // Polarity
    check("R6 all good active-high", 32'(pgOut), 32'hF);
    polHigh = 1'b0;
    #1 check("R6 active-low output", 32'(pgOut), 32'h0);
    regRead(8'h62, rd); check("R5 flags under active-low", 32'(rd[3:0]), 32'hF);
    polHigh = 1'b1;
    #1 check("R6 back to active-high", 32'(pgOut), 32'hF);

    // Immediate deassertion
    @(negedge clk);
    #2 setCh(2, 901, 100, 900);
    #1 check("R7 pgOut drop same cycle", 32'(pgOut), 32'hB);
    regRead(8'h62, rd); check("R7 status drop", 32'(rd[3:0]), 32'hB);
    @(negedge clk);

    // Restart after early loss on channel 0 (code 00)
    setCh(0, 0, 100, 900);
    @(negedge clk);
    setCh(0, 500, 100, 900);
    @(negedge clk);
    ticks(30);
    setCh(0, 50, 100, 900);
    @(negedge clk);
    setCh(0, 500, 100, 900);
    @(negedge clk);
    ticks(49);
    check("R8 restart not yet good", 32'(pgOut[0]), 32'h0);
    ticks(1);
    check("R8 restart good after full delay", 32'(pgOut[0]), 32'h1);

    // Delay write during timing
    setCh(0, 0, 100, 900);
    @(negedge clk);
    setCh(0, 500, 100, 900);
    @(negedge clk);
    ticks(10);
    regWrite(8'h66, 8'hE7);
    ticks(39);
    check("R9 old delay one early", 32'(pgOut[0]), 32'h0);
    ticks(1);
    check("R9 old delay kept", 32'(pgOut[0]), 32'h1);
    setCh(0, 0, 100, 900);
    @(negedge clk);
    setCh(0, 500, 100, 900);
    @(negedge clk);
    ticks(399);
    check("R9 new delay one early", 32'(pgOut[0]), 32'h0);
    ticks(1);
    check("R9 new delay applied", 32'(pgOut[0]), 32'h1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule